// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front End

This block is the host-facing register file of a two-channel serial controller. A byte-wide bus has read and write strobes and two address bits. Address bit 0 picks the channel and address bit 1 picks the data port or the control port. Both channels share one indirect register pointer. The host sets the pointer with a control write to command register 0, and the next control access then reaches the selected register. After that access the pointer falls back to 0. Registers 8 to 15 are reached by setting the pointer's top bit with a "point high" command in the same write.

Each channel holds:
- a data byte;
- two raw interrupt-mask bytes (registers 1 and 15);
- a mode byte (register 4), decoded into parity, stop-bit, sync-mode and clock-multiplier outputs.

The interrupt vector (register 2) and the master interrupt control byte (register 9) have one copy each, shared by the two channels. A write to command register 0 also produces one-cycle command strobes for the serial engines, which sit outside this block.

Top module: `serial_reg_front`

## Requirements
- R1: `addr[0]` selects channel A (0) or B (1), and `addr[1]` selects the data port (1) or the control port (0). A data write stores the byte for that channel only. A data read returns it on `rdData` in the same cycle as `rdEn`.
- R2: A synchronous active-high `rst` does all of the following:
  - clears the pointer;
  - sets both data bytes to 0xFF;
  - clears the masks, the vector, the master byte and both mode bytes, so parity is off, the stop field is synchronous, sync mode is monosync and the multiplier is 1;
  - clears all strobes.
- R3: A control write while the pointer is 0 loads pointer bits 2:0 from data bits 2:0. The next control write goes to the register the pointer selects, and afterwards the pointer is 0 again.
- R4: In a control write made while the pointer is 0, data bits 5:3 equal to 001 also set pointer bit 3. Otherwise pointer bit 3 is cleared.
- R5: Every control read returns 0x00 and leaves the pointer at 0. A data read does not change the pointer.
- R6: Registers 2 (`intVector`) and 9 (`masterCtl`) exist once. A write to either of them through either channel updates the single copy and changes no per-channel register.
- R7: Register 1 is stored raw in `txRxMask`, and register 15 is stored raw in `extMask`, separately for each channel.
- R8: Mode byte bit 0 drives `parityEn`. `parityEven` is bit 1 when parity is enabled (1 = even, 0 = odd) and is 0 when parity is off.
- R9: Mode byte bits 3:2 drive `stopSel`: 00 synchronous, 01 one bit, 10 one and a half bits, 11 two bits. Bits 5:4 drive `syncSel`: 00 monosync, 01 bisync, 10 SDLC, 11 external.
- R10: Mode byte bits 7:6 give `clkMult` as 1, 16, 32 or 64 for codes 00 to 11. `clkMult` is forced to 1 whenever the stop field is 00.
- R11: A write to command register 0 makes `cmdStrobe` pulse for one cycle, in the cycle after the write edge, on the addressed channel only.
  - Data bits 7:6 set strobe bit 0 (value 01, receive CRC reset), bit 1 (value 10, transmit CRC reset) or bit 2 (value 11, transmit underrun latch reset).
  - A value k from 2 to 7 in bits 5:3 sets strobe bit k+1, in this order: external/status reset, send abort, interrupt on next receive character, transmit interrupt pending reset, error reset, highest in-service reset.
- R12: A control write to a register number that is not implemented (0, 1, 2, 4, 9 and 15 are implemented) changes no output and returns the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| addr | input | 2 | Bit 0 channel, bit 1 data/control |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte (combinational) |
| parityEn | output | 2 | Per-channel parity enable |
| parityEven | output | 2 | Per-channel even parity select |
| stopSel | output | 2x2 | Per-channel stop-bit code |
| syncSel | output | 2x2 | Per-channel sync-mode code |
| clkMult | output | 2x7 | Per-channel clock multiplier value |
| txRxMask | output | 2x8 | Per-channel register 1 byte |
| extMask | output | 2x8 | Per-channel register 15 byte |
| intVector | output | 8 | Shared interrupt vector |
| masterCtl | output | 8 | Shared master interrupt control byte |
| cmdStrobe | output | 2x9 | Per-channel one-cycle command strobes |

## Verification
The assertions check these properties on every cycle:
- every command strobe comes from a control write to the same channel in the previous cycle;
- at most one strobe in each strobe group is active at a time;
- a synchronous stop field always gives a multiplier of 1;
- parity-even never shows while parity is off;
- control reads return zero;
- the masks and the vector change only after control writes.

Only the bench's scenarios can show that the shared pointer reaches the intended register. This covers pointer reload, the "point high" extension, the pointer clearing after reads and unimplemented writes, and data reads leaving it alone. The bench scenarios also confirm that the shared registers ignore which channel was addressed and that reset returns the pointer to zero.

// File: rtl/serial_reg_pkg.sv
package serial_reg_pkg;
  localparam int NUM_CH   = 2;
  localparam int DATA_W   = 8;
  localparam int PTR_W    = 4;
  localparam int NUM_CMD  = 9;
  localparam int MULT_W   = 7;

  localparam logic [PTR_W-1:0] REG_CMD     = 4'd0;
  localparam logic [PTR_W-1:0] REG_XFER    = 4'd1;
  localparam logic [PTR_W-1:0] REG_VECTOR  = 4'd2;
  localparam logic [PTR_W-1:0] REG_MODE    = 4'd4;
  localparam logic [PTR_W-1:0] REG_MASTER  = 4'd9;
  localparam logic [PTR_W-1:0] REG_EXT     = 4'd15;

  localparam logic [2:0] CMD_POINT_HIGH = 3'b001;

  typedef struct packed {
    logic ch;
    logic ldData;
    logic ldCmd;
    logic ldXfer;
    logic ldMode;
    logic ldExt;
    logic ldVector;
    logic ldMaster;
  } regStrobes_t;

  function automatic logic [NUM_CMD-1:0] decodeCmd(input logic [DATA_W-1:0] v);
    logic [NUM_CMD-1:0] f;
    f = '0;
    case (v[7:6])
      2'b01:   f[0] = 1'b1;
      2'b10:   f[1] = 1'b1;
      2'b11:   f[2] = 1'b1;
      default: ;
    endcase
    for (int k = 0; k < 6; k++) begin
      if (v[5:3] == 3'(k + 2)) f[k+3] = 1'b1;
    end
    return f;
  endfunction
endpackage

// File: rtl/serial_reg_ctrl.sv
module serial_reg_ctrl
  import serial_reg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic [1:0]  addr,
  input  logic [5:0]  ptrBits,
  output regStrobes_t strb
);
  logic [PTR_W-1:0] ptr;
  logic ctrlAccess;

  assign ctrlAccess = !addr[1];

  always_comb begin
    strb    = '0;
    strb.ch = addr[0];
    if (wrEn) begin
      if (addr[1]) begin
        strb.ldData = 1'b1;
      end else if (ptr == REG_CMD) begin
        strb.ldCmd = 1'b1;
      end else begin
        case (ptr)
          REG_XFER:   strb.ldXfer   = 1'b1;
          REG_VECTOR: strb.ldVector = 1'b1;
          REG_MODE:   strb.ldMode   = 1'b1;
          REG_MASTER: strb.ldMaster = 1'b1;
          REG_EXT:    strb.ldExt    = 1'b1;
          default:    ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (wrEn && ctrlAccess) begin
      if (ptr == REG_CMD)
        ptr <= {(ptrBits[5:3] == CMD_POINT_HIGH), ptrBits[2:0]};
      else
        ptr <= '0;
    end else if (rdEn && ctrlAccess) begin
      ptr <= '0;
    end
  end
endmodule

// File: rtl/serial_reg_dp.sv
module serial_reg_dp
  import serial_reg_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst,
  input  regStrobes_t                         strb,
  input  logic [DATA_W-1:0]                   wrData,
  input  logic                                rdEn,
  input  logic                                rdIsData,
  input  logic                                rdCh,
  output logic [DATA_W-1:0]                   rdData,
  output logic [NUM_CH-1:0]                   parityEn,
  output logic [NUM_CH-1:0]                   parityEven,
  output logic [NUM_CH-1:0][1:0]              stopSel,
  output logic [NUM_CH-1:0][1:0]              syncSel,
  output logic [NUM_CH-1:0][MULT_W-1:0]       clkMult,
  output logic [NUM_CH-1:0][DATA_W-1:0]       txRxMask,
  output logic [NUM_CH-1:0][DATA_W-1:0]       extMask,
  output logic [DATA_W-1:0]                   intVector,
  output logic [DATA_W-1:0]                   masterCtl,
  output logic [NUM_CH-1:0][NUM_CMD-1:0]      cmdStrobe
);
  logic [NUM_CH-1:0][DATA_W-1:0] dataReg;
  logic [NUM_CH-1:0][DATA_W-1:0] modeReg;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = (strb.ch == 1'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        dataReg[c]   <= '1;
        modeReg[c]   <= '0;
        txRxMask[c]  <= '0;
        extMask[c]   <= '0;
        cmdStrobe[c] <= '0;
      end else begin
        cmdStrobe[c] <= '0;
        if (hit) begin
          if (strb.ldData) dataReg[c]   <= wrData;
          if (strb.ldXfer) txRxMask[c]  <= wrData;
          if (strb.ldExt)  extMask[c]   <= wrData;
          if (strb.ldMode) modeReg[c]   <= wrData;
          if (strb.ldCmd)  cmdStrobe[c] <= decodeCmd(wrData);
        end
      end
    end

    always_comb begin
      parityEn[c]   = modeReg[c][0];
      parityEven[c] = modeReg[c][0] & modeReg[c][1];
      stopSel[c]    = modeReg[c][3:2];
      syncSel[c]    = modeReg[c][5:4];
      case (modeReg[c][7:6])
        2'b01:   clkMult[c] = 7'd16;
        2'b10:   clkMult[c] = 7'd32;
        2'b11:   clkMult[c] = 7'd64;
        default: clkMult[c] = 7'd1;
      endcase
      if (modeReg[c][3:2] == 2'b00) clkMult[c] = 7'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intVector <= '0;
      masterCtl <= '0;
    end else begin
      if (strb.ldVector) intVector <= wrData;
      if (strb.ldMaster) masterCtl <= wrData;
    end
  end

  assign rdData = (rdEn && rdIsData) ? dataReg[rdCh] : '0;
endmodule

// File: rtl/serial_reg_front.sv
module serial_reg_front
  import serial_reg_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rdEn,
  input  logic                           wrEn,
  input  logic [1:0]                     addr,
  input  logic [7:0]                     wrData,
  output logic [7:0]                     rdData,
  output logic [1:0]                     parityEn,
  output logic [1:0]                     parityEven,
  output logic [1:0][1:0]                stopSel,
  output logic [1:0][1:0]                syncSel,
  output logic [1:0][6:0]                clkMult,
  output logic [1:0][7:0]                txRxMask,
  output logic [1:0][7:0]                extMask,
  output logic [7:0]                     intVector,
  output logic [7:0]                     masterCtl,
  output logic [1:0][8:0]                cmdStrobe
);
  regStrobes_t strb;

  serial_reg_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .rdEn    (rdEn),
    .wrEn    (wrEn),
    .addr    (addr),
    .ptrBits (wrData[5:0]),
    .strb    (strb)
  );

  serial_reg_dp dp_i (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .wrData     (wrData),
    .rdEn       (rdEn),
    .rdIsData   (addr[1]),
    .rdCh       (addr[0]),
    .rdData     (rdData),
    .parityEn   (parityEn),
    .parityEven (parityEven),
    .stopSel    (stopSel),
    .syncSel    (syncSel),
    .clkMult    (clkMult),
    .txRxMask   (txRxMask),
    .extMask    (extMask),
    .intVector  (intVector),
    .masterCtl  (masterCtl),
    .cmdStrobe  (cmdStrobe)
  );
endmodule

// File: rtl/serial_reg_front_chk.sv
module serial_reg_front_chk (
  input logic            clk,
  input logic            rst,
  input logic            rdEn,
  input logic            wrEn,
  input logic [1:0]      addr,
  input logic [7:0]      rdData,
  input logic [1:0]      parityEn,
  input logic [1:0]      parityEven,
  input logic [1:0][1:0] stopSel,
  input logic [1:0][6:0] clkMult,
  input logic [1:0][7:0] txRxMask,
  input logic [7:0]      intVector,
  input logic [1:0][8:0] cmdStrobe
);
  for (genvar c = 0; c < 2; c++) begin : g_chk
    AST_STROBE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
      (cmdStrobe[c] != '0) |-> $past(wrEn && !addr[1] && (addr[0] == 1'(c)))); // R11
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(cmdStrobe[c][2:0]) && $onehot0(cmdStrobe[c][8:3])); // R11
    AST_SYNC_MULT_ONE: assert property (@(posedge clk) disable iff (rst)
      (stopSel[c] == 2'b00) |-> (clkMult[c] == 7'd1)); // R10
    AST_PARITY_OFF_NOT_EVEN: assert property (@(posedge clk) disable iff (rst)
      !parityEn[c] |-> !parityEven[c]); // R8
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
      !$stable(txRxMask[c]) |-> $past(wrEn && !addr[1])); // R7
  end

  AST_VECTOR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(intVector) |-> $past(wrEn && !addr[1])); // R6
  AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdEn && !addr[1]) |-> (rdData == 8'h00)); // R5
endmodule

bind serial_reg_front serial_reg_front_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .rdEn       (rdEn),
  .wrEn       (wrEn),
  .addr       (addr),
  .rdData     (rdData),
  .parityEn   (parityEn),
  .parityEven (parityEven),
  .stopSel    (stopSel),
  .clkMult    (clkMult),
  .txRxMask   (txRxMask),
  .intVector  (intVector),
  .cmdStrobe  (cmdStrobe)
);

// File: tb/serial_reg_front_tb_top.sv
`timescale 1ns/1ps
module serial_reg_front_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rdEn = 1'b0, wrEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [1:0] parityEn, parityEven;
  logic [1:0][1:0] stopSel, syncSel;
  logic [1:0][6:0] clkMult;
  logic [1:0][7:0] txRxMask, extMask;
  logic [7:0] intVector, masterCtl;
  logic [1:0][8:0] cmdStrobe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_reg_front dut_i (
    .clk(clk), .rst(rst), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .parityEn(parityEn),
    .parityEven(parityEven), .stopSel(stopSel), .syncSel(syncSel),
    .clkMult(clkMult), .txRxMask(txRxMask), .extMask(extMask),
    .intVector(intVector), .masterCtl(masterCtl), .cmdStrobe(cmdStrobe)
  );

  typedef struct packed {
    logic [7:0] val;
    logic       pe;
    logic       ev;
    logic [1:0] stop;
    logic [1:0] sync;
    logic [6:0] mult;
  } modeVec_t;

  localparam int NVEC = 13;
  localparam modeVec_t MODE_TBL [NVEC] = '{
    '{8'h00, 1'b0, 1'b0, 2'd0, 2'd0, 7'd1},
    '{8'h01, 1'b1, 1'b0, 2'd0, 2'd0, 7'd1},
    '{8'h03, 1'b1, 1'b1, 2'd0, 2'd0, 7'd1},
    '{8'h02, 1'b0, 1'b0, 2'd0, 2'd0, 7'd1},
    '{8'h44, 1'b0, 1'b0, 2'd1, 2'd0, 7'd16},
    '{8'h88, 1'b0, 1'b0, 2'd2, 2'd0, 7'd32},
    '{8'hCC, 1'b0, 1'b0, 2'd3, 2'd0, 7'd64},
    '{8'hC0, 1'b0, 1'b0, 2'd0, 2'd0, 7'd1},
    '{8'h10, 1'b0, 1'b0, 2'd0, 2'd1, 7'd1},
    '{8'h20, 1'b0, 1'b0, 2'd0, 2'd2, 7'd1},
    '{8'h30, 1'b0, 1'b0, 2'd0, 2'd3, 7'd1},
    '{8'hFF, 1'b1, 1'b1, 2'd3, 2'd3, 7'd64},
    '{8'h5D, 1'b1, 1'b0, 2'd3, 2'd1, 7'd16}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic wrCtl(input logic ch, input logic [7:0] d);
    busWr({1'b0, ch}, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [8:0] expStr;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    busRd(2'b10, v); check("R2 data A reset", v, 8'hFF);
    busRd(2'b11, v); check("R2 data B reset", v, 8'hFF);
    check("R2 outputs reset", {parityEn, parityEven, stopSel, syncSel, txRxMask, extMask, intVector, masterCtl},
          '0);
    check("R2 mult reset", clkMult, {7'd1, 7'd1});

    // R8 R9 R10 mode decode table
    for (int i = 0; i < NVEC; i++) begin
      logic ch;
      ch = 1'(i % 2);
      wrCtl(ch, 8'h04);
      wrCtl(ch, MODE_TBL[i].val);
      check($sformatf("R8 R9 R10 mode vec %0d", i),
            {parityEn[ch], parityEven[ch], stopSel[ch], syncSel[ch], clkMult[ch]},
            {MODE_TBL[i].pe, MODE_TBL[i].ev, MODE_TBL[i].stop, MODE_TBL[i].sync, MODE_TBL[i].mult});
    end

    // R1 data per channel
    busWr(2'b10, 8'h5A);
    busWr(2'b11, 8'hC3);
    busRd(2'b10, v); check("R1 data A", v, 8'h5A);
    busRd(2'b11, v); check("R1 data B", v, 8'hC3);

    // R7 masks, R4 point high
    wrCtl(1'b0, 8'h01); wrCtl(1'b0, 8'h11);
    wrCtl(1'b1, 8'h0F); wrCtl(1'b1, 8'hF0);
    check("R7 txRxMask", txRxMask, {8'h00, 8'h11});
    check("R4 R7 extMask", extMask, {8'hF0, 8'h00});

    // R12 unimplemented register 7 (no point high)
    wrCtl(1'b0, 8'h07); wrCtl(1'b0, 8'hAA);
    check("R12 R4 ignored write", {txRxMask, extMask, intVector, masterCtl},
          {8'h00, 8'h11, 8'hF0, 8'h00, 8'h00, 8'h00});

    // R3 pointer returns to 0
    wrCtl(1'b0, 8'h01); wrCtl(1'b0, 8'h22);
    check("R3 reload after access", txRxMask[0], 8'h22);

    // R5 control read clears pointer and reads zero
    wrCtl(1'b0, 8'h01);
    busRd(2'b00, v); check("R5 control read zero", v, 8'h00);
    wrCtl(1'b0, 8'h04); wrCtl(1'b0, 8'h33);
    check("R5 pointer cleared by read", {txRxMask[0], parityEn[0], parityEven[0], stopSel[0], syncSel[0]},
          {8'h22, 1'b1, 1'b1, 2'd0, 2'd3});

    // R5 data read keeps pointer
    wrCtl(1'b0, 8'h01);
    busRd(2'b10, v); check("R1 data read A", v, 8'h5A);
    wrCtl(1'b0, 8'h66);
    check("R5 data read keeps pointer", txRxMask[0], 8'h66);

    // R6 shared registers
    wrCtl(1'b1, 8'h02); wrCtl(1'b1, 8'h9C);
    check("R6 vector via B", intVector, 8'h9C);
    wrCtl(1'b0, 8'h02); wrCtl(1'b0, 8'h4E);
    check("R6 vector via A", intVector, 8'h4E);
    wrCtl(1'b1, 8'h09); wrCtl(1'b1, 8'h81);
    check("R6 master via B", masterCtl, 8'h81);
    check("R6 per-channel untouched", {txRxMask, extMask}, {8'h00, 8'h66, 8'hF0, 8'h00});

    // R11 command strobes
    for (int k = 0; k < 10; k++) begin
      logic [7:0] cv;
      logic ch;
      ch = 1'(k % 2);
      case (k)
        0: begin cv = 8'h40; expStr = 9'h001; end
        1: begin cv = 8'h80; expStr = 9'h002; end
        2: begin cv = 8'hC0; expStr = 9'h004; end
        9: begin cv = 8'h70; expStr = 9'h081; end
        default: begin cv = 8'((k - 1) << 3); expStr = 9'(1 << k); end
      endcase
      wrCtl(ch, cv);
      check($sformatf("R11 strobe val %0h", cv), {cmdStrobe[ch], cmdStrobe[!ch]}, {expStr, 9'h000});
      @(negedge clk);
      check($sformatf("R11 strobe one cycle %0h", cv), cmdStrobe, '0);
    end

    // R2 mid-run reset clears pointer
    wrCtl(1'b0, 8'h01);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check("R2 reset regs", {txRxMask, extMask, intVector, masterCtl, stopSel, clkMult},
          {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 4'h0, 7'd1, 7'd1});
    busRd(2'b11, v); check("R2 data B after reset", v, 8'hFF);
    wrCtl(1'b0, 8'h0F); wrCtl(1'b0, 8'h77);
    check("R2 R4 pointer cleared by reset", {extMask[0], txRxMask[0]}, {8'h77, 8'h00});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule